// File: doc/BRIEF.md
# Continuous Sync-Slot Frame Transmitter

This block drives one shared serial line as the master of a group of receivers. Time is cut into frames of a configurable number of system clocks. Early in every frame the line carries a sync pulse of configurable width. Its rising edge is the only timing reference a receiver needs. A fixed number of data bits follows right after the pulse, and the line then rests low until the frame ends.

Receivers stay locked only if pulses keep arriving, so frames never stop. When no word is offered at a frame start, the frame still goes out with its sync pulse and an all-zero data field. A producer offers a word by holding it with a valid flag. The word is taken only in the single clock when the block signals it is ready, which is the first clock of a frame.

Frame length, sync width and bit width are static configuration inputs. A combinational check rejects any setting that would not fit in one frame. While the setting is rejected, the line and the ready pulse stay silent.

Top module: `syncFrameTx`

## Requirements
- R1: While reset is asserted the line is low. In the first clock after reset is released, `dataReady` is high and the line is low; that clock is position 0 of a frame.
- R2: Frame positions run 0 to `frameLen`-1 and repeat. `dataReady` is high exactly in position 0, so it is a one-clock pulse every `frameLen` clocks.
- R3: The line is high in positions `SYNC_OFS` (default 2) through `SYNC_OFS`+`syncWidth`-1 of every frame.
- R4: The data bits come MSB first, starting right after the sync pulse. Bit k (k=0 is the MSB) is driven for `bitWidth` clocks from position `SYNC_OFS`+`syncWidth`+k*`bitWidth`.
- R5: The line is low in positions 0 to `SYNC_OFS`-1 and from the end of the last data bit to the end of the frame.
- R6: The word sent in a frame is `dataIn` as sampled in that frame's position 0 with `dataValid` high. Changes to `dataIn` in any other position do not alter the transmitted bits.
- R7: If `dataValid` is low in position 0, the frame still carries its sync pulse and all of its data bits are 0.
- R8: `cfgError` is high exactly when `syncWidth` is 0, `bitWidth` is 0, or `SYNC_OFS`+`syncWidth`+`DATA_W`*`bitWidth` >= `frameLen`. While it is high, the line and `dataReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameLen | input | FRAME_W | Frame length in clocks |
| syncWidth | input | SYNC_CW | Sync pulse width in clocks |
| bitWidth | input | BIT_CW | Clocks per data bit |
| dataIn | input | DATA_W | Payload word offered to the next frame |
| dataValid | input | 1 | Payload word is valid |
| dataReady | output | 1 | One-clock pulse at frame position 0; the word is taken here |
| lineOut | output | 1 | Serial line |
| cfgError | output | 1 | Configuration does not fit in a frame |

## Verification
All outputs follow registered frame state with no added delay. In frame position p (counting clocks since reset release, modulo `frameLen`), `dataReady` and `lineOut` show the value for p itself. The bench compares them at the falling edge inside clock p, against a model indexed by p. A word offered in position 0 is captured at that clock's rising edge. Its first data bit appears `SYNC_OFS`+`syncWidth` clocks later, so the model latches its expected payload only after checking position 0. `cfgError` is combinational from the configuration and is compared in every clock.

// File: rtl/sync_frame_pkg.sv
package sync_frame_pkg;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_SYNC,
    PH_DATA,
    PH_TAIL
  } phase_e;

  typedef struct packed {
    logic capture;
    logic driveSync;
    logic driveData;
  } strobes_t;

endpackage

// File: rtl/sfCtrl.sv
module sfCtrl
  import sync_frame_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FRAME_W  = 9,
  parameter int SYNC_CW  = 4,
  parameter int BIT_CW   = 5,
  parameter int SYNC_OFS = 2,
  localparam int IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic [SYNC_CW-1:0] syncWidth,
  input  logic [BIT_CW-1:0]  bitWidth,
  output strobes_t           strb,
  output logic [IDX_W-1:0]   bitIdx,
  output logic               cfgErr
);

  localparam int TMR_W = (SYNC_CW > BIT_CW) ? SYNC_CW : BIT_CW;
  localparam int SUM_W = FRAME_W + BIT_CW + SYNC_CW;

  phase_e             phase;
  logic [FRAME_W-1:0] cnt;
  logic [TMR_W-1:0]   tmr;
  logic [SUM_W-1:0]   needLen;
  logic               wrap;
  logic               leadDone;
  logic               syncLast;
  logic               bitLast;
  logic               wordLast;

  // Fit check: lead gap, sync pulse and every data bit must end before the last position.
  always_comb begin
    needLen = SUM_W'(SYNC_OFS) + SUM_W'(syncWidth) + SUM_W'(DATA_W) * SUM_W'(bitWidth);
    cfgErr  = (syncWidth == '0) || (bitWidth == '0) || (needLen >= SUM_W'(frameLen));
  end

  always_comb begin
    wrap     = (cnt >= frameLen - FRAME_W'(1));
    leadDone = (cnt == FRAME_W'(SYNC_OFS - 1));
    syncLast = (tmr == TMR_W'(syncWidth) - TMR_W'(1));
    bitLast  = (tmr == TMR_W'(bitWidth) - TMR_W'(1));
    wordLast = (bitIdx == IDX_W'(DATA_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || cfgErr) begin
      cnt    <= '0;
      phase  <= PH_LEAD;
      tmr    <= '0;
      bitIdx <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + FRAME_W'(1);
      unique case (phase)
        PH_LEAD: begin
          if (leadDone) begin
            phase <= PH_SYNC;
            tmr   <= '0;
          end
        end
        PH_SYNC: begin
          if (syncLast) begin
            phase  <= PH_DATA;
            tmr    <= '0;
            bitIdx <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        PH_DATA: begin
          if (bitLast) begin
            tmr <= '0;
            if (wordLast) phase <= PH_TAIL;
            else          bitIdx <= bitIdx + IDX_W'(1);
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: ;
      endcase
      if (wrap) phase <= PH_LEAD;
    end
  end

  always_comb begin
    strb.capture   = !cfgErr && (cnt == '0);
    strb.driveSync = !cfgErr && (phase == PH_SYNC);
    strb.driveData = !cfgErr && (phase == PH_DATA);
  end

endmodule

// File: rtl/sfData.sv
module sfData
  import sync_frame_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  output logic              lineOut,
  output logic              dataReady
);

  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] payload;

  always_ff @(posedge clk) begin
    if (!rstN)             payload <= '0;
    else if (strb.capture) payload <= dataValid ? dataIn : '0;
  end

  always_comb begin
    lineOut   = strb.driveSync || (strb.driveData && payload[TOP_BIT - bitIdx]);
    dataReady = strb.capture;
  end

endmodule

// File: rtl/syncFrameTx.sv
module syncFrameTx
  import sync_frame_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FRAME_W  = 9,
  parameter int SYNC_CW  = 4,
  parameter int BIT_CW   = 5,
  parameter int SYNC_OFS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic [SYNC_CW-1:0] syncWidth,
  input  logic [BIT_CW-1:0]  bitWidth,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               dataValid,
  output logic               dataReady,
  output logic               lineOut,
  output logic               cfgError
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  strobes_t         strb;
  logic [IDX_W-1:0] bitIdx;
  logic             cfgErr;

  sfCtrl #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .SYNC_CW (SYNC_CW),
    .BIT_CW  (BIT_CW),
    .SYNC_OFS(SYNC_OFS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameLen (frameLen),
    .syncWidth(syncWidth),
    .bitWidth (bitWidth),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .cfgErr   (cfgErr)
  );

  sfData #(
    .DATA_W(DATA_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .dataIn   (dataIn),
    .dataValid(dataValid),
    .lineOut  (lineOut),
    .dataReady(dataReady)
  );

  assign cfgError = cfgErr;

endmodule

// File: rtl/sfChecker.sv
module sfChecker
  import sync_frame_pkg::*;
#(
  parameter int FRAME_W = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic [FRAME_W-1:0] frameLen,
  input logic               lineOut,
  input logic               dataReady,
  input logic               cfgErr,
  input strobes_t           strb
);

  logic [FRAME_W-1:0] gapCnt;
  logic               seenReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= '0;
      seenReady <= 1'b0;
    end else if (dataReady) begin
      gapCnt    <= '0;
      seenReady <= 1'b1;
    end else begin
      gapCnt <= gapCnt + FRAME_W'(1);
    end
  end

  AST_READY_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && seenReady) |-> (gapCnt == frameLen - FRAME_W'(1))); // R2

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |=> !dataReady); // R2

  AST_SYNC_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveSync |-> lineOut); // R3

  AST_DATA_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.driveSync) |-> strb.driveData); // R4

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.driveSync && !strb.driveData) |-> !lineOut); // R5

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!lineOut && !dataReady)); // R8

endmodule

bind syncFrameTx sfChecker #(.FRAME_W(FRAME_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .frameLen (frameLen),
  .lineOut  (lineOut),
  .dataReady(dataReady),
  .cfgErr   (cfgErr),
  .strb     (strb)
);

// File: tb/tb_syncFrameTx.sv
module tb_syncFrameTx;

  localparam int DATA_W   = 8;
  localparam int FRAME_W  = 9;
  localparam int SYNC_CW  = 4;
  localparam int BIT_CW   = 5;
  localparam int SYNC_OFS = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [FRAME_W-1:0] frameLen = '0;
  logic [SYNC_CW-1:0] syncWidth = '0;
  logic [BIT_CW-1:0]  bitWidth = '0;
  logic [DATA_W-1:0]  dataIn = '0;
  logic               dataValid = 1'b0;
  logic               dataReady;
  logic               lineOut;
  logic               cfgError;

  int vecCnt = 0;
  int badCnt = 0;

  always #5 clk = ~clk;

  syncFrameTx #(
    .DATA_W(DATA_W), .FRAME_W(FRAME_W), .SYNC_CW(SYNC_CW),
    .BIT_CW(BIT_CW), .SYNC_OFS(SYNC_OFS)
  ) dut (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .syncWidth(syncWidth),
    .bitWidth(bitWidth), .dataIn(dataIn), .dataValid(dataValid),
    .dataReady(dataReady), .lineOut(lineOut), .cfgError(cfgError)
  );

  function automatic bit expErrFn(int fl, int s, int b);
    return (s == 0) || (b == 0) || (SYNC_OFS + s + DATA_W * b >= fl);
  endfunction

  function automatic bit expLineFn(int p, logic [DATA_W-1:0] pay, int s, int b);
    int q;
    if (p < SYNC_OFS) return 1'b0;
    if (p < SYNC_OFS + s) return 1'b1;
    q = p - SYNC_OFS - s;
    if (q < DATA_W * b) return pay[DATA_W - 1 - q / b];
    return 1'b0;
  endfunction

  function automatic string regionTag(int p, int s, int b, string dataTag);
    if (p >= SYNC_OFS && p < SYNC_OFS + s) return "R3";
    if (p >= SYNC_OFS + s && p < SYNC_OFS + s + DATA_W * b) return dataTag;
    return "R5";
  endfunction

  task automatic check1(string tag, string what, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      badCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic runCfg(int fl, int s, int b, int frames, int validPct, string dataTag);
    bit                err;
    logic [DATA_W-1:0] expPay;
    int                p;
    err       = expErrFn(fl, s, b);
    rstN      = 1'b0;
    dataValid = 1'b0;
    frameLen  = FRAME_W'(fl);
    syncWidth = SYNC_CW'(s);
    bitWidth  = BIT_CW'(b);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R1", "line in reset", int'(lineOut), 0);
    rstN   = 1'b1;
    expPay = '0;
    for (int c = 0; c < frames * fl; c++) begin
      p = c % fl;
      check1("R8", "cfgError", int'(cfgError), int'(err));
      if (err) begin
        check1("R8", "ready under error", int'(dataReady), 0);
        check1("R8", "line under error", int'(lineOut), 0);
      end else begin
        check1((c == 0) ? "R1" : "R2", "ready", int'(dataReady), int'(p == 0));
        check1((c == 0) ? "R1" : regionTag(p, s, b, dataTag), "line",
               int'(lineOut), int'(expLineFn(p, expPay, s, b)));
      end
      dataIn    = DATA_W'($urandom);
      dataValid = ($urandom % 100) < validPct;
      if (!err && p == 0) expPay = dataValid ? dataIn : '0;
      @(negedge clk);
    end
  endtask

  initial begin
    int s;
    int b;
    int fl;
    void'($urandom(32'd4711));
    runCfg(50, 5, 5, 6, 70, "R4");
    runCfg(250, 10, 20, 4, 70, "R4");
    runCfg(12, 1, 1, 20, 50, "R4");
    runCfg(11, 1, 1, 3, 50, "R4");
    runCfg(60, 6, 6, 5, 0, "R7");
    runCfg(60, 6, 6, 5, 100, "R6");
    runCfg(100, 0, 4, 2, 50, "R4");
    runCfg(40, 3, 0, 2, 50, "R4");
    for (int k = 0; k < 8; k++) begin
      s  = 1 + int'($urandom % 15);
      b  = 1 + int'($urandom % 31);
      fl = SYNC_OFS + s + DATA_W * b + 1 + int'($urandom % 20);
      runCfg(fl, s, b, 3, 60, "R4");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    badCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

endmodule